// File: doc/BRIEF.md
# Microsequencer Next-Address Unit With Conditional Branching

This block holds the microprogram counter of a microprogrammed controller and decides, on every clock, which control-store address comes next. The control store sits outside the block. It returns the word at the current counter value, and three fields of that word come back into this block:

- an end-of-routine bit,
- a three-bit branch condition selector,
- a branch target address.

The CPU supplies its status flags, the opcode held in the instruction register, and a strobe that marks the cycle in which a new instruction is placed there.

There are four candidate next addresses, chosen in strict priority:

1. The start of the opcode's microroutine, when the strobe is high.
2. The first word of the fetch routine (address 0), when the end bit is set.
3. The branch target, when the selected condition holds.
4. The counter plus one, in every other case.

The start address of each opcode's routine is computed from the opcode by a parameterized linear map. It is not looked up in a table. With the default settings, opcode 6 starts at address 25. A branch-if-negative routine placed there behaves as follows. Its first word returns to fetch when N is clear. Otherwise the counter moves on to 26 and then to 27, and word 27 ends the routine.

Top module: `useq_branch_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, the counter becomes 0 after that edge. This holds whatever the other inputs are.
- R2: With no dispatch, no end bit and no taken branch, the counter advances by one per clock. It wraps from 255 to 0.
- R3: When ir_load is high, the next counter value is (1 + 4*opcode) mod 256, for example 25 for opcode 6. This takes precedence over the end bit and over any branch.
- R4: When ir_load is low and uw_end is high, the next counter value is 0. This takes precedence over a taken branch.
- R5: When ir_load and uw_end are low and the condition holds, the next counter value is uw_target. Flag bit 0 is N and flag bit 1 is Z. The uw_cond codes are 001 always, 010 N=1, 011 N=0, 100 Z=1 and 101 Z=0.
- R6: Code 000, and any code from R5 whose flag test fails, makes the counter increment as in R2.
- R7: Codes 110 and 111 never branch, whatever the flags are.
- R8: The opcode value has no effect on the counter while ir_load is low.
- R9: Flag bits 2 and 3 have no effect on any branch decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_load | input | 1 | High in the cycle a new instruction enters the instruction register |
| opcode | input | 4 | Opcode of the instruction register |
| uw_end | input | 1 | End-of-routine bit of the current microinstruction |
| uw_cond | input | 3 | Branch condition selector of the current microinstruction |
| uw_target | input | 8 | Branch target address of the current microinstruction |
| flags | input | 4 | CPU status flags; bit 0 = N, bit 1 = Z |
| upc | output | 8 | Microprogram counter, the control-store address |

## Verification
The properties assume that the microinstruction fields and flags are stable and known during each clock cycle. They also assume that ir_load, uw_end and uw_cond are never X after reset.

The stimulus changes every input only on the falling clock edge and always drives defined values, so each rising edge sees one settled set of inputs. The random phase also stays within these limits:

- ir_load is driven high rarely, so that long runs of increments, branches and wraps still occur.
- All eight condition codes and all sixteen flag patterns are used, which exercises the reserved codes and the unused flag bits alongside the defined tests.

// File: rtl/useq_pkg.sv
package useq_pkg;

   localparam int COND_W = 3;

   // Branch condition selector carried in each microinstruction
   typedef enum logic [COND_W-1:0] {
      COND_NEVER  = 3'b000,
      COND_ALWAYS = 3'b001,
      COND_NEG    = 3'b010,
      COND_NONNEG = 3'b011,
      COND_ZERO   = 3'b100,
      COND_NZERO  = 3'b101,
      COND_RSV6   = 3'b110,
      COND_RSV7   = 3'b111
   } cond_e;

   // Which source fed the next counter value
   typedef enum logic [1:0] {
      SRC_INC    = 2'd0,
      SRC_ENTRY  = 2'd1,
      SRC_FETCH  = 2'd2,
      SRC_BRANCH = 2'd3
   } src_e;

endpackage

// File: rtl/useq_cond_eval.sv
module useq_cond_eval import useq_pkg::*; #(
   parameter int FLAG_W   = 4,
   parameter int NEG_BIT  = 0,
   parameter int ZERO_BIT = 1
) (
   input  logic [COND_W-1:0] cond,
   input  logic [FLAG_W-1:0] flags,
   output logic              taken
);

   logic neg_f;
   logic zero_f;
   logic unused_flags;

   assign neg_f  = flags[NEG_BIT];
   assign zero_f = flags[ZERO_BIT];

   // Fold every flag bit into one unused net so that no bit is left dangling.
   assign unused_flags = ^flags;

   always_comb begin
      unique case (cond_e'(cond))
         COND_NEVER:  taken = 1'b0;
         COND_ALWAYS: taken = 1'b1;
         COND_NEG:    taken = neg_f;
         COND_NONNEG: taken = ~neg_f;
         COND_ZERO:   taken = zero_f;
         COND_NZERO:  taken = ~zero_f;
         default:     taken = 1'b0;
      endcase
   end

   initial begin
      assert (NEG_BIT >= 0 && NEG_BIT < FLAG_W)
         else $error("NEG_BIT outside flag vector");
      assert (ZERO_BIT >= 0 && ZERO_BIT < FLAG_W)
         else $error("ZERO_BIT outside flag vector");
      assert (NEG_BIT != ZERO_BIT)
         else $error("N and Z must use distinct flag bits");
   end

endmodule

// File: rtl/useq_entry_map.sv
module useq_entry_map #(
   parameter int OP_W   = 4,
   parameter int ADDR_W = 8,
   parameter int BASE   = 1,
   parameter int STRIDE = 4
) (
   input  logic [OP_W-1:0]   opcode,
   output logic [ADDR_W-1:0] entry
);

   localparam int  PW       = ADDR_W + OP_W;
   localparam bit  IS_POW2  = (STRIDE > 0) && ((STRIDE & (STRIDE - 1)) == 0);
   localparam int  SHIFT    = (STRIDE > 1) ? $clog2(STRIDE) : 0;
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

   logic [PW-1:0]     wide_op;
   logic [ADDR_W-1:0] scaled;

   assign wide_op = PW'(opcode);

   generate
      if (IS_POW2) begin : g_shift
         // A power-of-two stride needs only a wired shift.
         logic [PW-1:0] shifted;
         assign shifted = wide_op << SHIFT;
         assign scaled  = shifted[ADDR_W-1:0];
      end else begin : g_mult
         // Any other stride uses a constant multiplier.
         logic [PW-1:0] product;
         assign product = wide_op * PW'(STRIDE);
         assign scaled  = product[ADDR_W-1:0];
      end
   endgenerate

   assign entry = scaled + BASE_V;

   initial begin
      assert (STRIDE >= 1) else $error("STRIDE must be positive");
      assert (BASE >= 0)   else $error("BASE must be non-negative");
   end

endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel import useq_pkg::*; #(
   parameter int ADDR_W     = 8,
   parameter int FETCH_ADDR = 0
) (
   input  logic              ir_load,
   input  logic              end_bit,
   input  logic              taken,
   input  logic [ADDR_W-1:0] cur,
   input  logic [ADDR_W-1:0] entry,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] nxt,
   output src_e              src
);

   localparam logic [ADDR_W-1:0] FETCH_V = ADDR_W'(FETCH_ADDR);
   localparam logic [ADDR_W-1:0] ONE_V   = ADDR_W'(1);

   logic [ADDR_W-1:0] inc_addr;

   assign inc_addr = cur + ONE_V;

   // Dispatch outranks end-of-routine, which outranks a taken branch.
   always_comb begin
      if (ir_load) begin
         src = SRC_ENTRY;
      end else if (end_bit) begin
         src = SRC_FETCH;
      end else if (taken) begin
         src = SRC_BRANCH;
      end else begin
         src = SRC_INC;
      end
   end

   always_comb begin
      unique case (src)
         SRC_ENTRY:  nxt = entry;
         SRC_FETCH:  nxt = FETCH_V;
         SRC_BRANCH: nxt = target;
         default:    nxt = inc_addr;
      endcase
   end

endmodule

// File: rtl/useq_branch_seq.sv
module useq_branch_seq import useq_pkg::*; #(
   parameter int ADDR_W       = 8,
   parameter int OP_W         = 4,
   parameter int FLAG_W       = 4,
   parameter int NEG_BIT      = 0,
   parameter int ZERO_BIT     = 1,
   parameter int FETCH_ADDR   = 0,
   parameter int ENTRY_BASE   = 1,
   parameter int ENTRY_STRIDE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ir_load,
   input  logic [OP_W-1:0]   opcode,
   input  logic              uw_end,
   input  logic [COND_W-1:0] uw_cond,
   input  logic [ADDR_W-1:0] uw_target,
   input  logic [FLAG_W-1:0] flags,
   output logic [ADDR_W-1:0] upc
);

   localparam logic [ADDR_W-1:0] FETCH_V = ADDR_W'(FETCH_ADDR);
   localparam logic [ADDR_W-1:0] ONE_V   = ADDR_W'(1);

   logic              br_taken;
   logic [ADDR_W-1:0] entry_addr;
   logic [ADDR_W-1:0] upc_nxt;
   src_e              nxt_src;

   useq_cond_eval #(
      .FLAG_W   (FLAG_W),
      .NEG_BIT  (NEG_BIT),
      .ZERO_BIT (ZERO_BIT)
   ) u_cond (
      .cond  (uw_cond),
      .flags (flags),
      .taken (br_taken)
   );

   useq_entry_map #(
      .OP_W   (OP_W),
      .ADDR_W (ADDR_W),
      .BASE   (ENTRY_BASE),
      .STRIDE (ENTRY_STRIDE)
   ) u_map (
      .opcode (opcode),
      .entry  (entry_addr)
   );

   useq_next_sel #(
      .ADDR_W     (ADDR_W),
      .FETCH_ADDR (FETCH_ADDR)
   ) u_sel (
      .ir_load (ir_load),
      .end_bit (uw_end),
      .taken   (br_taken),
      .cur     (upc),
      .entry   (entry_addr),
      .target  (uw_target),
      .nxt     (upc_nxt),
      .src     (nxt_src)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upc <= FETCH_V;
      end else begin
         upc <= upc_nxt;
      end
   end

   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= 16)
         else $error("ADDR_W out of range");
      assert (OP_W >= 1 && OP_W <= 12)
         else $error("OP_W out of range");
      assert (FETCH_ADDR >= 0 && FETCH_ADDR < (1 << ADDR_W))
         else $error("FETCH_ADDR does not fit the counter");
   end

   // ---------------- assertions ----------------
   AST_IR_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ir_load |=> (upc == $past(entry_addr)));  // R3

   AST_END_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!ir_load && uw_end) |=> (upc == FETCH_V));  // R4

   AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ir_load && !uw_end && br_taken) |=> (upc == $past(uw_target)));  // R5

   AST_NOT_TAKEN_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (!ir_load && !uw_end && !br_taken) |=> (upc == $past(upc) + ONE_V));  // R6

   AST_RSV_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!ir_load && !uw_end && uw_cond[2] && uw_cond[1])
         |=> (upc == $past(upc) + ONE_V));  // R7

   AST_SRC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_src == SRC_INC) |=> (upc == $past(upc) + ONE_V));  // R2

endmodule

// File: tb/tb_useq_branch_seq.sv
module tb_useq_branch_seq;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ir_load;
   logic [3:0] opcode;
   logic       uw_end;
   logic [2:0] uw_cond;
   logic [7:0] uw_target;
   logic [3:0] flags;
   logic [7:0] upc;

   int  checks   = 0;
   int  failures = 0;
   int  exp_upc  = 0;
   bit  done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   useq_branch_seq dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ir_load   (ir_load),
      .opcode    (opcode),
      .uw_end    (uw_end),
      .uw_cond   (uw_cond),
      .uw_target (uw_target),
      .flags     (flags),
      .upc       (upc)
   );

   // Behavioural reference model: one call gives the next counter value.
   function automatic int model_next(int cur, bit irl, int op, bit e,
                                     int c, int tgt, int fl);
      int  n = fl & 1;
      int  z = (fl >> 1) & 1;
      bit  tk;
      case (c)
         1:       tk = 1'b1;
         2:       tk = (n == 1);
         3:       tk = (n == 0);
         4:       tk = (z == 1);
         5:       tk = (z == 0);
         default: tk = 1'b0;
      endcase
      if (irl)     return (1 + 4 * op) % 256;
      else if (e)  return 0;
      else if (tk) return tgt;
      else         return (cur + 1) % 256;
   endfunction

   task automatic check_upc(string req);
      checks++;
      if (int'(upc) !== exp_upc) begin
         failures++;
         $display("FAIL %s upc actual=%0d expected=%0d t=%0t", req, upc, exp_upc, $time);
      end
   endtask

   // Drive one microinstruction after a falling edge, then compare on the next falling edge.
   task automatic step(bit irl, int op, bit e, int c, int tgt, int fl, string req);
      ir_load   = irl;
      opcode    = 4'(op);
      uw_end    = e;
      uw_cond   = 3'(c);
      uw_target = 8'(tgt);
      flags     = 4'(fl);
      exp_upc   = model_next(exp_upc, irl, op, e, c, tgt, fl);
      @(negedge clk);
      check_upc(req);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ir_load = 1'b1; opcode = 4'd9; uw_end = 1'b0;
      uw_cond = 3'd1; uw_target = 8'd77; flags = 4'd0;
      repeat (3) @(negedge clk);
      exp_upc = 0;
      check_upc("R1 reset state");
      rst_n = 1'b1;

      // R2: plain increment
      step(0, 0, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 0, 0, 0, "R2");
      // R3: dispatch of opcode 6 to the branch-if-negative routine at 25
      step(1, 6, 0, 0, 0, 0, "R3");
      // R6: word 25 branches on N=0, N is set, so proceed to 26
      step(0, 6, 0, 3, 0, 1, "R6");
      step(0, 6, 0, 0, 0, 1, "R2");
      // R4: word 27 ends, beating an always-branch to 99
      step(0, 6, 1, 1, 99, 0, "R4");
      step(0, 0, 0, 0, 0, 0, "R2");
      // R3: dispatch wins over end and branch together
      step(1, 6, 1, 1, 77, 0, "R3 priority");
      // R5: N=0, so word 25 returns to 0
      step(0, 6, 0, 3, 0, 0, "R5");
      // R8: opcode changes with ir_load low
      step(0, 15, 0, 0, 0, 0, "R8");
      step(0, 3, 0, 0, 0, 0, "R8");

      // R5/R6/R7/R9: every condition code against every flag pattern
      for (int c = 0; c < 8; c++) begin
         for (int fl = 0; fl < 16; fl++) begin
            if (c >= 6)
               step(0, 0, 0, c, 200 + fl, fl, "R7");
            else if (fl >= 4)
               step(0, 0, 0, c, 100 + fl, fl, "R9");
            else
               step(0, 0, 0, c, 100 + fl, fl, (c == 0) ? "R6" : "R5");
         end
      end

      // R2: wrap 255 -> 0
      step(0, 0, 0, 1, 255, 0, "R5");
      step(0, 0, 0, 0, 0, 0, "R2 wrap");
      // R3: largest opcode maps to 61
      step(1, 15, 0, 0, 0, 0, "R3");

      // R1: reset in mid-run beats a dispatch
      rst_n = 1'b0; ir_load = 1'b1; opcode = 4'd5; uw_end = 1'b0;
      uw_cond = 3'd1; uw_target = 8'd33;
      @(negedge clk);
      exp_upc = 0;
      check_upc("R1 mid-run");
      rst_n = 1'b1;

      // Random mix compared every cycle against the model
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 16) == 0, int'($urandom % 16), ($urandom % 10) == 0,
              int'($urandom % 8), int'($urandom % 256), int'($urandom % 16),
              "R2 random");
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule